// File: doc/BRIEF.md
# Sorting DMA copy engine

This block moves a single row of byte elements from a source region of memory to a destination region and puts the bytes in ascending order on the way. A controller sets the source address, destination address and element count, then raises `start`. The engine reads every element into a local buffer and orders the buffer with repeated adjacent compare-and-exchange passes. It then writes the ordered row out and raises `done`.

Both memory ports use active-low strokes. Each access holds its strobe, address and data until the memory returns ready. The time spent sorting depends on the data. Rows that are already in order cost one pass. A fully reversed row costs the maximum number of passes.

Top module: `sdma_sort_copy`

## Requirements
- R1: While reset is asserted and after it is released, `done` is low and both `mem_rd_n` and `mem_wr_n` are high.
- R2: A high `start` seen while idle captures `src_addr`, `dst_addr` and `col_cnt`. The block then reads addresses src+0 up to src+C-1 in increasing order. Each read holds `mem_rd_n` low with a stable address until a cycle in which `rd_rdy` is high, and the byte on `mem_rd_data` is taken in that cycle.
- R3: No destination write is issued before all C source reads have been accepted, and `mem_rd_n` and `mem_wr_n` are never low together.
- R4: The block writes C bytes to addresses dst+0 up to dst+C-1 in increasing order. The values are the source bytes in ascending unsigned order, duplicates kept. Each write holds `mem_wr_n` low with stable address and data until a cycle in which `wr_rdy` is high.
- R5: Each sorting cycle compares one adjacent buffer pair and exchanges the pair when the lower-index byte is greater. A pass is C-1 such compares. Sorting stops after the first pass with no exchange, or after C-1 passes. With both ready inputs held high, `done` rises exactly 2C+1+P(C-1) clock edges after `start` is first sampled. Here P = min(D+1, C-1), and D is the largest count, over all elements, of greater elements that precede that element in the source.
- R6: A count of 0 makes no memory access and `done` rises one edge after `start` is sampled. A count of 1 makes exactly one read and one write and copies the byte unchanged.
- R7: `done` rises one cycle after the last accepted write and stays high while `start` stays high. It falls on the edge after `start` is seen low, and the block is then ready for a new transfer.
- R8: A `col_cnt` above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Level request to begin a transfer; drop after done |
| src_addr | input | 16 | First source byte address |
| dst_addr | input | 16 | First destination byte address |
| col_cnt | input | 7 | Number of byte elements in the row |
| done | output | 1 | Transfer finished, held until start falls |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_data | input | 8 | Read data, valid while rd_rdy is high |
| rd_rdy | input | 1 | Read accepted this cycle |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_wr_addr | output | 16 | Write address |
| mem_wr_data | output | 8 | Write data |
| wr_rdy | input | 1 | Write accepted this cycle |

## Verification
The bench sweeps every ordering of four distinct values, along with short rows that are ascending, descending, constant or alternating. A compare with the wrong sense would produce descending output, and a signed compare would misplace bytes above 127. The cycle count to `done` is predicted from the inversion depth of each row. This count catches an engine that ignores the early stop, one that runs one pass too many, and one that stops a pass short at the full 64-element reversed row. Rows of length 0, 1 and an over-range count test the edge cases: an extra access, an off-by-one at the final element, or a missing clamp would each show up as a wrong address or a wrong write count. Random ready stalls show whether an access advances without being accepted.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_SORT,
    ST_WRITE,
    ST_DONE
  } sdma_state_e;
endpackage

// File: rtl/sdma_buf.sv
module sdma_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_data,
  input  logic          swp_en,
  output logic [DW-1:0] lo_data,
  output logic [DW-1:0] hi_data
);
  logic [DEPTH-1:0][DW-1:0] ent_q;
  logic [DEPTH-1:0][DW-1:0] ent_d;
  logic [IW-1:0]            idx_hi;

  assign idx_hi  = idx + IW'(1);
  assign lo_data = ent_q[idx];
  assign hi_data = ent_q[idx_hi];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    assign ent_d[k] = (ld_en  && idx    == IW'(k)) ? ld_data :
                      (swp_en && idx    == IW'(k)) ? hi_data :
                      (swp_en && idx_hi == IW'(k)) ? lo_data :
                      ent_q[k];
  end

  always_ff @(posedge clk) begin
    ent_q <= ent_d;
  end

  // R5
  swap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swp_en |-> (int'(idx) < DEPTH - 1));

  // R5
  swap_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(swp_en && ld_en));
endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 16,
  parameter int MAXC = 64,
  parameter int CW   = 7,
  parameter int IW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [CW-1:0] col_cnt,
  output logic          done,
  output logic          mem_rd_n,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          rd_rdy,
  output logic          mem_wr_n,
  output logic [AW-1:0] mem_wr_addr,
  input  logic          wr_rdy,
  output logic [IW-1:0] idx,
  output logic          ld_en,
  output logic          swp_en,
  input  logic [DW-1:0] lo_data,
  input  logic [DW-1:0] hi_data
);
  sdma_state_e   state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] pass_q, pass_d;
  logic          swp_q, swp_d;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q, cnt_in;
  logic          cfg_en;
  logic          gt, last_el, last_pair, last_pass;

  assign cnt_in    = (col_cnt > CW'(MAXC)) ? CW'(MAXC) : col_cnt;
  assign cfg_en    = (state_q == ST_IDLE) && start;
  assign gt        = lo_data > hi_data;
  assign last_el   = CW'(idx_q) == cnt_q - CW'(1);
  assign last_pair = CW'(idx_q) == cnt_q - CW'(2);
  assign last_pass = CW'(pass_q) + CW'(1) == cnt_q - CW'(1);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    pass_d  = pass_q;
    swp_d   = swp_q;
    ld_en   = 1'b0;
    swp_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          idx_d   = '0;
          state_d = (cnt_in == '0) ? ST_DONE : ST_READ;
        end
      end
      ST_READ: begin
        if (rd_rdy) begin
          ld_en = 1'b1;
          if (last_el) begin
            idx_d   = '0;
            pass_d  = '0;
            swp_d   = 1'b0;
            state_d = (cnt_q == CW'(1)) ? ST_WRITE : ST_SORT;
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      ST_SORT: begin
        swp_en = gt;
        if (last_pair) begin
          idx_d = '0;
          swp_d = 1'b0;
          if (!(swp_q || gt) || last_pass) state_d = ST_WRITE;
          else                             pass_d  = pass_q + IW'(1);
        end else begin
          idx_d = idx_q + IW'(1);
          swp_d = swp_q | gt;
        end
      end
      ST_WRITE: begin
        if (wr_rdy) begin
          if (last_el) state_d = ST_DONE;
          else         idx_d   = idx_q + IW'(1);
        end
      end
      ST_DONE: begin
        if (!start) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pass_q  <= '0;
      swp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pass_q  <= pass_d;
      swp_q   <= swp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_en) begin
      src_q <= src_addr;
      dst_q <= dst_addr;
      cnt_q <= cnt_in;
    end
  end

  assign idx         = idx_q;
  assign done        = state_q == ST_DONE;
  assign mem_rd_n    = state_q != ST_READ;
  assign mem_wr_n    = state_q != ST_WRITE;
  assign mem_rd_addr = src_q + AW'(idx_q);
  assign mem_wr_addr = dst_q + AW'(idx_q);

  // R1
  rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem_rd_n && mem_wr_n && !done));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n && !rd_rdy) |=> (!mem_rd_n && $stable(mem_rd_addr)));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n && !wr_rdy) |=> (!mem_wr_n && $stable(mem_wr_addr)));

  // R5
  pass_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SORT) |-> (CW'(pass_q) + CW'(1) <= cnt_q - CW'(1)));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_rd_n && mem_wr_n));
endmodule

// File: rtl/sdma_sort_copy.sv
module sdma_sort_copy #(
  parameter int DW   = 8,
  parameter int AW   = 16,
  parameter int MAXC = 64,
  localparam int CW  = $clog2(MAXC + 1),
  localparam int IW  = $clog2(MAXC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [CW-1:0] col_cnt,
  output logic          done,
  output logic          mem_rd_n,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  input  logic          rd_rdy,
  output logic          mem_wr_n,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          wr_rdy
);
  logic [IW-1:0] idx;
  logic          ld_en, swp_en;
  logic [DW-1:0] lo_data, hi_data;

  sdma_ctrl #(.DW(DW), .AW(AW), .MAXC(MAXC), .CW(CW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_addr(src_addr), .dst_addr(dst_addr), .col_cnt(col_cnt),
    .done(done),
    .mem_rd_n(mem_rd_n), .mem_rd_addr(mem_rd_addr), .rd_rdy(rd_rdy),
    .mem_wr_n(mem_wr_n), .mem_wr_addr(mem_wr_addr), .wr_rdy(wr_rdy),
    .idx(idx), .ld_en(ld_en), .swp_en(swp_en),
    .lo_data(lo_data), .hi_data(hi_data)
  );

  sdma_buf #(.DW(DW), .DEPTH(MAXC), .IW(IW)) u_buf (
    .clk(clk), .rst_n(rst_n), .idx(idx),
    .ld_en(ld_en), .ld_data(mem_rd_data), .swp_en(swp_en),
    .lo_data(lo_data), .hi_data(hi_data)
  );

  assign mem_wr_data = lo_data;
endmodule

// File: tb/sdma_sort_copy_tb.sv
module sdma_sort_copy_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] src_addr = '0, dst_addr = '0;
  logic [6:0]  col_cnt = '0;
  logic        done, mem_rd_n, mem_wr_n;
  logic [15:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]  mem_rd_data, mem_wr_data;
  logic        rd_rdy = 1'b1, wr_rdy = 1'b1;

  logic [7:0]  mem [0:1023];
  logic [7:0]  vals [0:63];
  logic [15:0] lfsr = 16'hACE1;
  bit          wait_en = 1'b0;
  int cur_src, cur_dst, cur_c, base_rd, base_wr;
  int n_rd = 0, n_wr = 0, err_rd = 0, err_wr = 0, err_early = 0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sdma_sort_copy u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_addr(src_addr), .dst_addr(dst_addr), .col_cnt(col_cnt),
    .done(done),
    .mem_rd_n(mem_rd_n), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .rd_rdy(rd_rdy),
    .mem_wr_n(mem_wr_n), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .wr_rdy(wr_rdy)
  );

  assign mem_rd_data = mem[mem_rd_addr[9:0]];

  // memory model and bus monitor, acting on the handshake the next edge completes
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_rdy = wait_en ? (lfsr[0] | lfsr[5]) : 1'b1;
    wr_rdy = wait_en ? (lfsr[2] & ~lfsr[7]) | lfsr[9] : 1'b1;
    if (!mem_rd_n && !mem_wr_n) err_early++;
    if (!mem_rd_n && rd_rdy) begin
      if (mem_rd_addr != 16'(cur_src + n_rd - base_rd)) err_rd++;
      n_rd++;
    end
    if (!mem_wr_n && wr_rdy) begin
      if (n_rd - base_rd != cur_c) err_early++;
      if (mem_wr_addr != 16'(cur_dst + n_wr - base_wr)) err_wr++;
      mem[mem_wr_addr[9:0]] = mem_wr_data;
      n_wr++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int c_in, input int src, input int dst, input bit waits);
    int c, d, p, lat, mism, er, ew, ee;
    logic [7:0] e [0:63];
    c = (c_in > 64) ? 64 : c_in;
    for (int k = 0; k < 64; k++) begin
      mem[src + k] = vals[k];
      e[k] = vals[k];
    end
    for (int k = 0; k < 70; k++) mem[dst + k] = 8'hEE;
    // expected ascending order (insertion sort)
    for (int i = 1; i < c; i++) begin
      logic [7:0] t;
      int j;
      t = e[i];
      j = i - 1;
      while (j >= 0 && e[j] > t) begin
        e[j + 1] = e[j];
        j--;
      end
      e[j + 1] = t;
    end
    d = 0;
    for (int i = 0; i < c; i++) begin
      int n;
      n = 0;
      for (int j = 0; j < i; j++) if (vals[j] > vals[i]) n++;
      if (n > d) d = n;
    end
    p = (c < 2) ? 0 : ((d + 1 < c - 1) ? d + 1 : c - 1);
    wait_en = waits;
    cur_src = src; cur_dst = dst; cur_c = c;
    base_rd = n_rd; base_wr = n_wr;
    er = err_rd; ew = err_wr; ee = err_early;
    @(negedge clk);
    src_addr = 16'(src); dst_addr = 16'(dst); col_cnt = 7'(c_in);
    start = 1'b1;
    lat = 0;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    check(done, "R7 watchdog", lat, 20000);
    if (!waits) check(lat == 2 * c + 1 + p * (c - 1), "R5 latency", lat, 2 * c + 1 + p * (c - 1));
    mism = 0;
    for (int k = 0; k < c; k++) if (mem[dst + k] != e[k]) mism++;
    if (mem[dst + c] != 8'hEE) mism++;
    check(mism == 0, "R4 sorted contents", mism, 0);
    check(n_rd - base_rd == c, "R2 R6 R8 read count", n_rd - base_rd, c);
    check(n_wr - base_wr == c, "R4 R6 R8 write count", n_wr - base_wr, c);
    check(err_rd == er, "R2 read order", err_rd - er, 0);
    check(err_wr == ew, "R4 write order", err_wr - ew, 0);
    check(err_early == ee, "R3 no early write", err_early - ee, 0);
    @(negedge clk);
    check(done && mem_rd_n && mem_wr_n, "R7 done held", done, 1);
    start = 1'b0;
    @(negedge clk);
    check(!done, "R7 done falls", done, 0);
    wait_en = 1'b0;
  endtask

  initial begin
    int pv [0:3];
    pv[0] = 10; pv[1] = 200; pv[2] = 3; pv[3] = 77;
    for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
    for (int k = 0; k < 64; k++) vals[k] = 8'(k * 37 + 11);
    repeat (3) @(negedge clk);
    check(!done && mem_rd_n && mem_wr_n, "R1 in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && mem_rd_n && mem_wr_n, "R1 after reset", done, 0);
    // R6 short rows
    run_case(0, 16'h100, 16'h200, 1'b0);
    vals[0] = 8'd201;
    run_case(1, 16'h100, 16'h200, 1'b0);
    // R5 all orderings of four distinct values
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              vals[0] = 8'(pv[a]); vals[1] = 8'(pv[b]);
              vals[2] = 8'(pv[c]); vals[3] = 8'(pv[d]);
              run_case(4, 16'h100, 16'h140, 1'b0);
            end
    // R4 R5 small sweep of patterns
    for (int n = 2; n <= 8; n++)
      for (int pat = 0; pat < 4; pat++) begin
        for (int k = 0; k < 64; k++)
          case (pat)
            0: vals[k] = 8'(k * 3);
            1: vals[k] = 8'(250 - k * 30);
            2: vals[k] = 8'd128;
            default: vals[k] = (k % 2 == 1) ? 8'(255 - k) : 8'(k);
          endcase
        run_case(n, 16'h180, 16'h260, pat == 3);
      end
    // R5 worst case, full reversal of 64
    for (int k = 0; k < 64; k++) vals[k] = 8'(200 - k);
    run_case(64, 16'h000, 16'h300, 1'b0);
    // R2 R4 stalls on a mixed full row
    for (int k = 0; k < 64; k++) vals[k] = 8'(k * 91 + 7);
    run_case(64, 16'h040, 16'h380, 1'b1);
    run_case(64, 16'h040, 16'h380, 1'b0);
    // R8 over-range count
    run_case(70, 16'h100, 16'h200, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule